// File: doc/BRIEF.md
# Greedy Medoid Seeding Engine

This block picks K representative points (medoids) out of N one-dimensional unsigned samples held in a small internal store. Selection is greedy. The first pick is the sample whose total absolute distance to every sample is smallest. Each later pick is the sample that gives the lowest clustering cost when it is added to the picks made so far. The clustering cost is the sum, over all samples, of the distance from each sample to its closest pick. The result is the list of pick indices in the order they were made, and the cost of the final set.

The cost of one candidate is split over P lanes. N is padded up to a multiple of P, so each lane walks an equal slice of the store and builds a partial sum. A single reduction stage then adds the partial sums and compares the total against the best candidate seen so far. Padded slots are masked: they add nothing to any sum and are never offered as candidates.

Software loads the samples through a write port while the engine is idle, then pulses `start` with the requested K. The engine raises `busy` until it pulses `done`. The pick list and cost are held until the next start.

Top module: `medoid_build_sel`

## Requirements
- R1: After reset, `busy` and `done` are 0, `cost` is 0 and every pick slot in `medoids` reads 0.
- R2: While idle, a cycle with `wr_en` high and `wr_addr` < N stores `wr_data` as sample `wr_addr`. Writes made while `busy` is high change nothing.
- R3: Pick slot 0 (bits IW-1:0 of `medoids`, IW = clog2(N)) holds the index c that minimises the sum over all N samples of |x_i − x_c|.
- R4: Pick slot s (bits s*IW +: IW), for s ≥ 1, holds the candidate that, added to picks 0..s−1, gives the minimum cost. Cost is the sum over samples of the distance to the nearest pick.
- R5: Cost ties go to the lower index. A sample that is already picked is never considered again, so all picks are distinct.
- R6: The effective K is `k_req`, clamped as follows: 0 becomes 1, and any value above min(KMAX, N) becomes that limit.
- R7: When N is not a multiple of P, the padded slots add nothing to any cost and never appear as a pick. Every pick index is below N.
- R8: At `done`, `cost` equals the cost of the final pick set. It is computed in CW-bit unsigned arithmetic that saturates at 2^CW − 1 instead of wrapping.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a single-cycle pulse with `busy` low. A `start` while busy is ignored.
- R10: Pick slots at or above the effective K read 0 after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Sample write strobe |
| wr_addr | input | clog2(N+1) | Sample index to write |
| wr_data | input | DW | Sample value |
| start | input | 1 | Begin a selection run |
| k_req | input | clog2(KMAX+1) | Requested number of picks |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| medoids | output | KMAX*IW | Pick indices, slot s at bits s*IW +: IW |
| cost | output | CW | Cost of the final pick set |

## Verification
The hardest case to reach from the ports is saturation. It takes sums wider than any realistic sample set produces, and it interacts with the tie rule, because many candidates can reach the same clamped maximum. The bench runs a second copy of the engine with an 8-bit cost beside the default one. Both copies receive every sample pattern, so widely spread data pushes the narrow copy's costs to the ceiling, and the narrow copy must then fall back to the lowest index. A run that receives a write and a second start while busy checks that neither one disturbs the result.

// File: rtl/medoid_build_sel.sv
module medoid_build_sel #(
  parameter int N    = 8,
  parameter int P    = 3,
  parameter int DW   = 8,
  parameter int KMAX = 4,
  parameter int CW   = 24
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [$clog2(N+1)-1:0]          wr_addr,
  input  logic [DW-1:0]                   wr_data,
  input  logic                            start,
  input  logic [$clog2(KMAX+1)-1:0]       k_req,
  output logic                            busy,
  output logic                            done,
  output logic [KMAX*((N>1)?$clog2(N):1)-1:0] medoids,
  output logic [CW-1:0]                   cost
);
  localparam int S   = (N + P - 1) / P;
  localparam int NP  = S * P;
  localparam int IW  = (N > 1) ? $clog2(N) : 1;
  localparam int CIW = $clog2(N + 1);
  localparam int KW  = $clog2(KMAX + 1);
  localparam int SW  = (S > 1) ? $clog2(S) : 1;
  localparam int KMX = (KMAX < N) ? KMAX : N;

  typedef enum logic [2:0] {IDLE, CAND, ACC, RED, COMMIT} st_t;

  function automatic logic [CW-1:0] sadd(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CW] ? {CW{1'b1}} : s[CW-1:0];
  endfunction

  function automatic logic [DW-1:0] adiff(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  st_t             st;
  logic [DW-1:0]   pts  [NP];
  logic [DW-1:0]   near [NP];
  logic [N-1:0]    chosen;
  logic [IW-1:0]   med  [KMAX];
  logic [CIW-1:0]  cand;
  logic [IW-1:0]   ci;
  logic [SW-1:0]   t;
  logic [KW-1:0]   step, keff;
  logic [CW-1:0]   best, cost_q, total;
  logic [IW-1:0]   bidx;
  logic            found, done_q, first;
  logic [DW-1:0]   xc, xb;

  assign ci    = cand[IW-1:0];
  assign first = (step == '0);
  assign xc    = pts[ci];
  assign xb    = pts[bidx];
  assign busy  = (st != IDLE);
  assign done  = done_q;
  assign cost  = cost_q;

  for (genvar s = 0; s < KMAX; s++) begin : g_out
    assign medoids[s*IW +: IW] = med[s];
  end

  for (genvar l = 0; l < P; l++) begin : g_lane
    int            j;
    logic [DW-1:0] d, m;
    logic [CW-1:0] c, pl, acc;
    assign j = l * S + int'(t);
    assign d = adiff(pts[j], xc);
    assign m = first ? d : ((d < near[j]) ? d : near[j]);
    assign c = (j >= N) ? '0 : CW'(m);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pl <= '0;
      else if (st == ACC) pl <= (t == '0) ? c : sadd(pl, c);
    end
    if (l == 0) begin : g_first
      assign acc = pl;
    end else begin : g_next
      assign acc = sadd(g_lane[l-1].acc, pl);
    end
  end
  assign total = g_lane[P-1].acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      cand   <= '0;
      t      <= '0;
      step   <= '0;
      keff   <= '0;
      best   <= '1;
      bidx   <= '0;
      found  <= 1'b0;
      cost_q <= '0;
      done_q <= 1'b0;
      chosen <= '0;
      for (int i = 0; i < NP; i++) begin
        pts[i]  <= '0;
        near[i] <= '0;
      end
      for (int i = 0; i < KMAX; i++) med[i] <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        IDLE: begin
          if (wr_en && (int'(wr_addr) < N)) pts[wr_addr] <= wr_data;
          if (start) begin
            keff   <= (k_req == '0) ? KW'(1) : ((int'(k_req) > KMX) ? KW'(KMX) : k_req);
            step   <= '0;
            cand   <= '0;
            found  <= 1'b0;
            best   <= '1;
            cost_q <= '0;
            chosen <= '0;
            for (int i = 0; i < KMAX; i++) med[i] <= '0;
            st     <= CAND;
          end
        end
        CAND: begin
          if (int'(cand) == N)  st <= COMMIT;
          else if (chosen[ci])  cand <= cand + 1'b1;
          else begin
            t  <= '0;
            st <= ACC;
          end
        end
        ACC: begin
          if (int'(t) == S - 1) begin
            t  <= '0;
            st <= RED;
          end else t <= t + 1'b1;
        end
        RED: begin
          if (!found || total < best) begin
            best  <= total;
            bidx  <= ci;
            found <= 1'b1;
          end
          cand <= cand + 1'b1;
          st   <= CAND;
        end
        COMMIT: begin
          med[step]    <= bidx;
          chosen[bidx] <= 1'b1;
          cost_q       <= best;
          for (int i = 0; i < NP; i++) begin
            if (first || adiff(pts[i], xb) < near[i]) near[i] <= adiff(pts[i], xb);
          end
          step  <= step + 1'b1;
          found <= 1'b0;
          best  <= '1;
          cand  <= '0;
          if (step + 1'b1 == keff) begin
            st     <= IDLE;
            done_q <= 1'b1;
          end else st <= CAND;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> !busy);
  // R4
  cost_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == COMMIT && step != '0) |-> best <= cost_q);
  // R5
  pick_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == COMMIT) |-> (found && !chosen[bidx]));
  // R7
  pick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == COMMIT) |-> (int'(bidx) < N));
endmodule

// File: tb/medoid_build_sel_tb.sv
module medoid_build_sel_tb;
  localparam int N = 8, P = 3, DW = 8, KMAX = 4;
  localparam int IW = 3, CIW = 4, KW = 3;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0;
  logic [CIW-1:0] wr_addr = '0;
  logic [DW-1:0]  wr_data = '0;
  logic [KW-1:0]  k_req = '0;
  logic busy_a, done_a, busy_b, done_b;
  logic [KMAX*IW-1:0] med_a, med_b;
  logic [23:0] cost_a;
  logic [7:0]  cost_b;

  int tests = 0, fails = 0;
  int dat [N];
  int exp_m [KMAX];
  int exp_c;

  always #10 clk = ~clk;

  medoid_build_sel #(.N(N), .P(P), .DW(DW), .KMAX(KMAX), .CW(24)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .k_req(k_req), .busy(busy_a), .done(done_a), .medoids(med_a), .cost(cost_a));

  medoid_build_sel #(.N(N), .P(P), .DW(DW), .KMAX(KMAX), .CW(8)) u_sat (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .k_req(k_req), .busy(busy_b), .done(done_b), .medoids(med_b), .cost(cost_b));

  task automatic check(input string req, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int pattern(input int p, input int i);
    int cl [8] = '{10, 11, 12, 200, 201, 202, 100, 101};
    case (p)
      0: return (i * 37 + 5) % 256;
      1: return 42;
      2: return cl[i];
      3: return 255 - i * 30;
      4: return (i % 2) ? 255 : 0;
      default: return (i * i * 13) % 256;
    endcase
  endfunction

  task automatic model(input int k, input int cw);
    int near [N];
    bit ch [N];
    int ke, lim, bc, bcost, sum, d;
    lim = (1 << cw) - 1;
    ke = (k == 0) ? 1 : ((k > KMAX) ? KMAX : k);
    for (int i = 0; i < N; i++) begin near[i] = 1 << 30; ch[i] = 0; end
    for (int s = 0; s < KMAX; s++) exp_m[s] = 0;
    for (int s = 0; s < ke; s++) begin
      bc = -1; bcost = 0;
      for (int c = 0; c < N; c++) begin
        if (ch[c]) continue;
        sum = 0;
        for (int j = 0; j < N; j++) begin
          d = (dat[j] > dat[c]) ? dat[j] - dat[c] : dat[c] - dat[j];
          sum += (d < near[j]) ? d : near[j];
        end
        if (sum > lim) sum = lim;
        if (bc < 0 || sum < bcost) begin bc = c; bcost = sum; end
      end
      ch[bc] = 1; exp_m[s] = bc; exp_c = bcost;
      for (int j = 0; j < N; j++) begin
        d = (dat[j] > dat[bc]) ? dat[j] - dat[bc] : dat[bc] - dat[j];
        if (d < near[j]) near[j] = d;
      end
    end
  endtask

  task automatic load();
    for (int i = 0; i < N; i++) begin
      @(negedge clk); wr_en = 1; wr_addr = CIW'(i); wr_data = DW'(dat[i]);
    end
    @(negedge clk); wr_en = 0;
  endtask

  task automatic run(input int k, input bit poke, input string tag);
    int cyc, dn;
    @(negedge clk); start = 1; k_req = KW'(k);
    @(negedge clk); start = 0;
    check("R9 busy after start", busy_a, 1);
    cyc = 0; dn = 0;
    while (!done_a && cyc < 5000) begin
      if (poke && cyc == 3) begin
        start = 1; k_req = KW'(1); wr_en = 1; wr_addr = '0; wr_data = DW'(dat[0] ^ 8'h55);
      end else begin
        start = 0; wr_en = 0;
      end
      @(negedge clk); cyc++;
    end
    start = 0; wr_en = 0;
    check({"R9 done reached ", tag}, done_a, 1);
    check("R9 idle at done", busy_a, 0);
    model(k, 24);
    for (int s = 0; s < KMAX; s++)
      check($sformatf("R3 R4 R5 R10 pick %0d %s", s, tag), int'(med_a[s*IW +: IW]), exp_m[s]);
    check({"R8 cost ", tag}, int'(cost_a), exp_c);
    model(k, 8);
    for (int s = 0; s < KMAX; s++)
      check($sformatf("R8 R5 sat pick %0d %s", s, tag), int'(med_b[s*IW +: IW]), exp_m[s]);
    check({"R8 sat cost ", tag}, int'(cost_b), exp_c);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); if (done_a) dn++;
    end
    check("R9 single done pulse", dn, 0);
    check("R9 stays idle", busy_a, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) dat[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 busy", busy_a, 0);
    check("R1 done", done_a, 0);
    check("R1 cost", int'(cost_a), 0);
    check("R1 picks", int'(med_a), 0);
    rst_n = 1;
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < N; i++) dat[i] = pattern(p, i);
      load();
      for (int k = 0; k <= 5; k++) run(k, 1'b0, $sformatf("R6 R7 p%0d k%0d", p, k));
    end
    for (int i = 0; i < N; i++) dat[i] = pattern(2, i);
    load();
    run(3, 1'b1, "R2 R9 poke");
    run(3, 1'b0, "R2 after poke");
    dat[5] = 0;
    @(negedge clk); wr_en = 1; wr_addr = CIW'(5); wr_data = '0;
    @(negedge clk); wr_en = 0;
    run(2, 1'b0, "R2 idle write");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule